// File: doc/BRIEF.md
# Fractional-Ratio Resampler Front-End

This block sits between an oversampling ADC core and an integer decimate-by-N stage. It turns the core's sample stream, running at the modulator rate, into a stream at N times the wanted output data rate. The step between output instants is an unsigned fixed-point ratio with 8 integer and 24 fraction bits. That ratio equals the core rate divided by N times the output rate, so it can take any fine-grained non-integer value. A phase accumulator tracks where each output instant falls between two input samples. Each output is a linear blend of those two neighbours.

The ratio comes from one of two places. In programmed mode it is a register value supplied by the host. The block then also produces the output-rate strobe by counting every N-th resampled output, so the strobe is derived from the sampling clock. In measured mode the output-rate clock is an external pin with no phase or frequency relation to the sampling clock. The block passes that pin through a synchronizer and counts sampling-clock cycles over 16 of its periods. From that count it derives the ratio itself.

A new ratio is adopted only when an output is produced, so no interpolation ever straddles a step change. If the external clock stops, a stale flag rises and the last measured ratio stays in force.

Top module: `frac_resampler`

## Requirements
- R1: While reset is held and right after it, out_valid, odr_tick and meas_stale are 0 and ratio_used reads 1.0 (0x0100_0000).
- R2: Input samples x0, x1, ... are counted from the first in_valid after reset. Output j lies at position j·r, where r is the effective ratio in 8.24 format. It is produced with out_valid one cycle after the input with index floor(j·r)+1 is accepted. At most one output follows each accepted input. Cycles without in_valid neither advance the phase nor produce an output.
- R3: For an output at position p with integer part i, out_data = x[i] + floor((x[i+1]−x[i])·w/4096). Samples are 16-bit two's complement, and w is bits 23:12 of the fractional part of p.
- R4: A selected ratio below 1.0 is treated as exactly 1.0, and ratio_used never reads below 1.0.
- R5: The ratio in force, shown on ratio_used, changes only in a cycle where out_valid is 1. A ratio change made between outputs takes effect at the next output.
- R6: In programmed mode, odr_tick is 1 together with every N-th output, with N = 2^N_LOG2 (default 4). The count of outputs starts from reset or from leaving measured mode. In measured mode odr_tick stays 0.
- R7: In measured mode, the selected ratio is the sum of 16 consecutive odr_in periods, measured in clk cycles, divided by 16·N and expressed in 8.24. The first rising edge after reset or after a timeout only starts timing. odr_in may be fully asynchronous to clk.
- R8: If no rising edge of odr_in is seen for 2^TMO_LOG2 clk cycles, meas_stale goes to 1 and the last measured ratio stays in force. The next rising edge clears meas_stale and restarts the 16-period measurement.
- R9: mode_meas = 1 selects the measured ratio and mode_meas = 0 selects cfg_ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_meas | input | 1 | 1 selects the measured ratio, 0 the programmed one |
| cfg_ratio | input | RI+RF (32) | Programmed ratio, unsigned 8.24 |
| odr_in | input | 1 | External output-rate clock, asynchronous |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DW (16) | Input sample, two's complement |
| out_valid | output | 1 | Resampled output strobe |
| out_data | output | DW (16) | Resampled output sample |
| odr_tick | output | 1 | Output-rate strobe in programmed mode |
| ratio_used | output | RI+RF (32) | Ratio currently applied to the phase step |
| meas_stale | output | 1 | External clock has been silent too long |

## Verification
On every cycle, the assertions check four things. Outputs appear only after an accepted input. The phase stays frozen on idle cycles. The applied ratio moves only at output boundaries and never drops below 1.0. The strobe accompanies outputs only in programmed mode. In the meter, they also check that no measurement is published on the edge that first starts timing, and that a stale condition keeps the measured value fixed. The exact sample values and the emission pattern for several ratios, ramps and gapped input streams are shown only by the bench scenarios. The same holds for the measured ratio for an integer and a non-integer external period, and for the recovery after the external clock goes silent.

// File: rtl/frs_pkg.sv
`timescale 1ns/1ps
package frs_pkg;

   typedef enum logic {
      SRC_SET  = 1'b0,
      SRC_MEAS = 1'b1
   } ratio_src_e;

   // fixed-point 1.0 for a given number of fraction bits
   function automatic logic [63:0] fx_one(input int frac_bits);
      return 64'd1 << frac_bits;
   endfunction

endpackage

// File: rtl/frs_odr_meter.sv
`timescale 1ns/1ps
module frs_odr_meter #(
   parameter int RI       = 8,
   parameter int RF       = 24,
   parameter int N_LOG2   = 2,
   parameter int AVG_LOG2 = 4,
   parameter int TMO_LOG2 = 20,
   parameter int SYNC_N   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             odr_in,
   output logic [RI+RF-1:0] meas_ratio,
   output logic             stale
);
   import frs_pkg::*;

   localparam int RATIO_W = RI + RF;
   localparam int CNT_W   = TMO_LOG2 + 1;
   localparam int SUM_W   = CNT_W + AVG_LOG2;
   localparam int SHIFT   = RF - AVG_LOG2 - N_LOG2;
   localparam int WIDE_W  = SUM_W + SHIFT;
   localparam logic [CNT_W-1:0]   TMO_MAX = CNT_W'(fx_one(TMO_LOG2) - 64'd1);
   localparam logic [RATIO_W-1:0] ONE_R   = RATIO_W'(fx_one(RF));

   initial begin
      assert (SYNC_N >= 2) else $error("meter: SYNC_N must be at least 2");
      assert (SHIFT >= 0) else $error("meter: RF too small for AVG_LOG2+N_LOG2");
      assert (AVG_LOG2 >= 1) else $error("meter: AVG_LOG2 must be at least 1");
   end

   logic [SYNC_N-1:0]   sync_q;
   logic                odr_last;
   logic                rise;
   logic [CNT_W-1:0]    cnt;
   logic                primed;
   logic [AVG_LOG2-1:0] per_idx;
   logic [SUM_W-1:0]    sum;
   logic [SUM_W-1:0]    sum_n;
   logic [RATIO_W-1:0]  conv;

   assign rise  = sync_q[SYNC_N-1] & ~odr_last;
   assign sum_n = sum + SUM_W'(cnt) + SUM_W'(1);

   // sum/(16*N) in 8.24 is a left shift; saturate only if the shifted sum can overflow
   if (WIDE_W > RATIO_W) begin : g_sat
      logic [WIDE_W-1:0] wide;
      assign wide = WIDE_W'(sum_n) << SHIFT;
      assign conv = (|wide[WIDE_W-1:RATIO_W]) ? '1 : wide[RATIO_W-1:0];
   end else begin : g_fit
      assign conv = RATIO_W'(sum_n) << SHIFT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q     <= '0;
         odr_last   <= 1'b0;
         cnt        <= '0;
         primed     <= 1'b0;
         per_idx    <= '0;
         sum        <= '0;
         meas_ratio <= ONE_R;
         stale      <= 1'b0;
      end else begin
         sync_q   <= {sync_q[SYNC_N-2:0], odr_in};
         odr_last <= sync_q[SYNC_N-1];
         if (rise) begin
            cnt    <= '0;
            primed <= 1'b1;
            stale  <= 1'b0;
            if (primed) begin
               if (per_idx == '1) begin
                  meas_ratio <= conv;
                  sum        <= '0;
               end else begin
                  sum <= sum_n;
               end
               per_idx <= per_idx + 1'b1;
            end
         end else if (cnt == TMO_MAX) begin
            cnt     <= '0;
            primed  <= 1'b0;
            stale   <= 1'b1;
            sum     <= '0;
            per_idx <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_STALE_HOLDS_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
      (stale && $past(stale)) |-> $stable(meas_ratio))
      else $error("measured ratio moved while stale"); // R8

   AST_FIRST_EDGE_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(primed) |-> $stable(meas_ratio))
      else $error("measured ratio moved before timing started"); // R7

endmodule

// File: rtl/frs_phase_acc.sv
`timescale 1ns/1ps
module frs_phase_acc #(
   parameter int DW = 16,
   parameter int RI = 8,
   parameter int RF = 24,
   parameter int WB = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [DW-1:0]    in_data,
   input  logic [RI+RF-1:0] ratio_src,
   output logic             emit,
   output logic [WB-1:0]    weight,
   output logic [DW-1:0]    x_prev,
   output logic [RI+RF-1:0] ratio_q
);
   import frs_pkg::*;

   localparam int RATIO_W = RI + RF;
   localparam int ACC_W   = RATIO_W + 1;
   localparam logic [RATIO_W-1:0] ONE_R = RATIO_W'(fx_one(RF));
   localparam logic [ACC_W-1:0]   ONE_A = ACC_W'(fx_one(RF));

   initial begin
      assert (WB >= 1 && WB <= RF) else $error("phase: WB must lie in 1..RF");
   end

   logic               primed;
   logic [ACC_W-1:0]   acc;      // distance from x_prev to the next output instant
   logic               below_one;
   logic [RATIO_W-1:0] ratio_eff;

   assign ratio_eff = (ratio_src < ONE_R) ? ONE_R : ratio_src;
   assign below_one = (acc[ACC_W-1:RF] == '0);
   assign emit      = in_valid & primed & below_one;
   assign weight    = acc[RF-1 -: WB];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed  <= 1'b0;
         acc     <= '0;
         x_prev  <= '0;
         ratio_q <= ONE_R;
      end else if (in_valid) begin
         x_prev <= in_data;
         if (!primed) begin
            primed <= 1'b1;
         end else if (below_one) begin
            acc     <= acc + ACC_W'(ratio_eff) - ONE_A;
            ratio_q <= ratio_eff;
         end else begin
            acc <= acc - ONE_A;
         end
      end
   end

   AST_IDLE_HOLDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(acc))
      else $error("phase advanced without an input"); // R2

endmodule

// File: rtl/frs_lerp.sv
`timescale 1ns/1ps
module frs_lerp #(
   parameter int DW = 16,
   parameter int WB = 12
) (
   input  logic [DW-1:0] x0,
   input  logic [DW-1:0] x1,
   input  logic [WB-1:0] weight,
   output logic [DW-1:0] y
);
   logic signed [DW:0]      diff;
   logic signed [DW+WB+1:0] prod;
   logic signed [DW+WB+1:0] scaled;
   logic                    unused_hi;

   assign diff      = $signed({x1[DW-1], x1}) - $signed({x0[DW-1], x0});
   assign prod      = diff * $signed({1'b0, weight});
   assign scaled    = prod >>> WB;
   // result lies between x0 and x1, so the low DW bits carry it exactly
   assign y         = x0 + scaled[DW-1:0];
   assign unused_hi = ^scaled[DW+WB+1:DW];

endmodule

// File: rtl/frac_resampler.sv
`timescale 1ns/1ps
module frac_resampler #(
   parameter int DW       = 16,
   parameter int RI       = 8,
   parameter int RF       = 24,
   parameter int WB       = 12,
   parameter int N_LOG2   = 2,
   parameter int AVG_LOG2 = 4,
   parameter int TMO_LOG2 = 20,
   parameter int SYNC_N   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_meas,
   input  logic [RI+RF-1:0] cfg_ratio,
   input  logic             odr_in,
   input  logic             in_valid,
   input  logic [DW-1:0]    in_data,
   output logic             out_valid,
   output logic [DW-1:0]    out_data,
   output logic             odr_tick,
   output logic [RI+RF-1:0] ratio_used,
   output logic             meas_stale
);
   import frs_pkg::*;

   localparam int RATIO_W = RI + RF;
   localparam logic [RATIO_W-1:0] ONE_R = RATIO_W'(fx_one(RF));

   initial begin
      assert (DW >= 2) else $error("top: DW too small");
      assert (TMO_LOG2 >= 4 && TMO_LOG2 <= 30) else $error("top: TMO_LOG2 out of range");
      assert (N_LOG2 >= 0 && N_LOG2 <= 8) else $error("top: N_LOG2 out of range");
   end

   ratio_src_e         src_sel;
   logic [RATIO_W-1:0] meas_ratio;
   logic [RATIO_W-1:0] ratio_src;
   logic               emit;
   logic [WB-1:0]      weight;
   logic [DW-1:0]      x_prev;
   logic [DW-1:0]      lerp_y;
   logic               tick_d;

   assign src_sel   = mode_meas ? SRC_MEAS : SRC_SET;
   assign ratio_src = (src_sel == SRC_MEAS) ? meas_ratio : cfg_ratio;

   frs_odr_meter #(
      .RI(RI), .RF(RF), .N_LOG2(N_LOG2), .AVG_LOG2(AVG_LOG2),
      .TMO_LOG2(TMO_LOG2), .SYNC_N(SYNC_N)
   ) u_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .odr_in     (odr_in),
      .meas_ratio (meas_ratio),
      .stale      (meas_stale)
   );

   frs_phase_acc #(
      .DW(DW), .RI(RI), .RF(RF), .WB(WB)
   ) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .ratio_src (ratio_src),
      .emit      (emit),
      .weight    (weight),
      .x_prev    (x_prev),
      .ratio_q   (ratio_used)
   );

   frs_lerp #(
      .DW(DW), .WB(WB)
   ) u_lerp (
      .x0     (x_prev),
      .x1     (in_data),
      .weight (weight),
      .y      (lerp_y)
   );

   // output-rate strobe: every 2^N_LOG2-th output in programmed mode
   if (N_LOG2 == 0) begin : g_div1
      assign tick_d = emit & (src_sel == SRC_SET);
   end else begin : g_divn
      logic [N_LOG2-1:0] dec_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dec_cnt <= '0;
         end else if (src_sel == SRC_MEAS) begin
            dec_cnt <= '0;
         end else if (emit) begin
            dec_cnt <= dec_cnt + 1'b1;
         end
      end
      assign tick_d = emit & (src_sel == SRC_SET) & (dec_cnt == '1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         odr_tick  <= 1'b0;
      end else begin
         out_valid <= emit;
         odr_tick  <= tick_d;
         if (emit) begin
            out_data <= lerp_y;
         end
      end
   end

   AST_OUT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid))
      else $error("output without a preceding input"); // R2

   AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(ratio_used))
      else $error("ratio changed between outputs"); // R5

   AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_used >= ONE_R)
      else $error("ratio in force below 1.0"); // R4

   AST_TICK_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      odr_tick |-> (out_valid && !$past(mode_meas)))
      else $error("strobe outside programmed-mode output"); // R6

endmodule

// File: tb/sim_frac_resampler.sv
`timescale 1ns/1ps
module sim_frac_resampler;

   localparam logic [31:0] ONE = 32'h0100_0000;

   typedef struct packed {
      logic [31:0] ratio;
      int          base;
      int          step;
      logic        gap;
      int          n_out;
   } row_t;

   // ratio, ramp base, ramp step, idle cycle between inputs, outputs from 32 inputs
   localparam row_t ROWS [6] = '{
      '{32'h0100_0000,      0,   100, 1'b0, 31},
      '{32'h0280_0000,   -500,    37, 1'b0, 13},
      '{32'h0140_0000,   1000,   -37, 1'b0, 25},
      '{32'h0300_0000,  32000, -2000, 1'b1, 11},
      '{32'h0080_0000,      7,     3, 1'b0, 31},
      '{32'h0155_5555, -32000,  2011, 1'b1, 24}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_meas = 1'b0;
   logic [31:0] cfg_ratio = ONE;
   logic        odr_in = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic        out_valid;
   logic [15:0] out_data;
   logic        odr_tick;
   logic [31:0] ratio_used;
   logic        meas_stale;

   always #5 clk = ~clk;

   frac_resampler #(.TMO_LOG2(10)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_meas  (mode_meas),
      .cfg_ratio  (cfg_ratio),
      .odr_in     (odr_in),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .odr_tick   (odr_tick),
      .ratio_used (ratio_used),
      .meas_stale (meas_stale)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit odr_run = 1'b0;
   int odr_half = 50;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                  req, what, act, act, exp, exp);
      end
   endtask

   // external output-rate clock, period 2*odr_half ns, unrelated to clk
   initial begin
      forever begin
         if (odr_run) begin
            odr_in = 1'b1;
            #(odr_half);
            odr_in = 1'b0;
            #(odr_half);
         end else begin
            #10;
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one input accepted at the next rising edge; outputs sampled 1 ns after it
   task automatic push(input logic [15:0] d);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic stream(input int n, output int outs, output int ticks);
      outs  = 0;
      ticks = 0;
      for (int i = 0; i < n; i++) begin
         push(16'(i * 13));
         if (out_valid) outs++;
         if (odr_tick) ticks++;
      end
   endtask

   task automatic run_row(input row_t rw);
      int     xs [32];
      longint t_next = 0;
      longint r_eff;
      int     j = 0;
      int     got = 0;
      int     ticks = 0;
      bit     bad_time = 0;
      bit     bad_val = 0;
      int     act_y = 0;
      int     exp_y = 0;
      do_reset();
      mode_meas = 1'b0;
      cfg_ratio = rw.ratio;
      r_eff = (rw.ratio < ONE) ? longint'(ONE) : longint'(rw.ratio);
      for (int k = 0; k < 32; k++) begin
         xs[k] = rw.base + rw.step * k;
         if (rw.gap && k > 0) @(negedge clk);
         push(16'(xs[k]));
         if (out_valid) got++;
         if (odr_tick) ticks++;
         if (k >= 1 && (t_next >> 24) == longint'(k - 1)) begin
            int idx;
            int w;
            int e;
            idx = k - 1;
            w   = int'((t_next >> 12) & 64'hFFF);
            e   = xs[idx] + (((xs[idx+1] - xs[idx]) * w) >>> 12);
            if (!out_valid || (odr_tick != ((j % 4) == 3))) bad_time = 1;
            if (out_valid && int'($signed(out_data)) != e && !bad_val) begin
               bad_val = 1;
               act_y   = int'($signed(out_data));
               exp_y   = e;
            end
            t_next += r_eff;
            j++;
         end else if (out_valid || odr_tick) begin
            bad_time = 1;
         end
      end
      check(!bad_time, "R2", "output instants follow j*r", bad_time, 0);
      check(got == rw.n_out, "R2", "output count from 32 inputs", got, rw.n_out);
      check(!bad_val, "R3", "interpolated value", act_y, exp_y);
      check(ratio_used == 32'(r_eff), "R4", "ratio in force", ratio_used, r_eff);
      check(ticks == got / 4, "R6", "strobe every 4th output", ticks, got / 4);
   endtask

   initial begin
      #1_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int outs;
      int ticks;
      // reset state
      repeat (2) @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
      check(odr_tick == 1'b0, "R1", "odr_tick in reset", odr_tick, 0);
      check(meas_stale == 1'b0, "R1", "meas_stale in reset", meas_stale, 0);
      check(ratio_used == ONE, "R1", "ratio_used in reset", ratio_used, ONE);
      rst_n = 1'b1;
      @(negedge clk);
      check(ratio_used == ONE && !out_valid, "R1", "state after reset", ratio_used, ONE);

      // vector table in programmed mode
      for (int r = 0; r < 6; r++) run_row(ROWS[r]);

      // R5: ratio change between outputs waits for the next output
      do_reset();
      mode_meas = 1'b0;
      cfg_ratio = 32'h0300_0000;
      push(16'd0);
      push(16'd10);
      check(out_valid && ratio_used == 32'h0300_0000, "R5", "first output adopts 3.0",
            ratio_used, 32'h0300_0000);
      cfg_ratio = ONE;
      push(16'd20);
      check(!out_valid && ratio_used == 32'h0300_0000, "R5", "held after change, input 2",
            ratio_used, 32'h0300_0000);
      push(16'd30);
      check(!out_valid && ratio_used == 32'h0300_0000, "R5", "held after change, input 3",
            ratio_used, 32'h0300_0000);
      push(16'd40);
      check(out_valid && ratio_used == ONE, "R5", "new ratio at next output", ratio_used, ONE);
      check(out_data == 16'd30, "R3", "output at position 3", out_data, 30);

      // R7: measured mode, period 10 clk cycles, N=4 -> 2.5
      do_reset();
      mode_meas = 1'b1;
      odr_half  = 50;
      odr_run   = 1'b1;
      stream(260, outs, ticks);
      check(ratio_used == 32'h0280_0000, "R7", "measured ratio, period 10", ratio_used,
            32'h0280_0000);
      check(ticks == 0 && outs > 0, "R6", "no strobe in measured mode", ticks, 0);
      check(meas_stale == 1'b0, "R8", "not stale while running", meas_stale, 0);

      // R8: silence beyond 2^10 cycles
      odr_run = 1'b0;
      repeat (1200) @(negedge clk);
      check(meas_stale == 1'b1, "R8", "stale after silence", meas_stale, 1);
      stream(10, outs, ticks);
      check(ratio_used == 32'h0280_0000, "R8", "last ratio held", ratio_used, 32'h0280_0000);

      // recovery with period 6 cycles -> 1.5
      odr_half = 30;
      odr_run  = 1'b1;
      repeat (40) @(negedge clk);
      check(meas_stale == 1'b0, "R8", "stale cleared by edge", meas_stale, 0);
      stream(200, outs, ticks);
      check(ratio_used == 32'h0180_0000, "R7", "measured ratio, period 6", ratio_used,
            32'h0180_0000);

      // asynchronous period 7.4 cycles -> 16-period sum 118 or 119, ratio sum/64
      odr_half = 37;
      stream(400, outs, ticks);
      check(ratio_used >= (32'd118 << 18) && ratio_used <= (32'd119 << 18), "R7",
            "measured ratio, async period 7.4", ratio_used, 32'd118 << 18);

      // R9: back to programmed ratio
      mode_meas = 1'b0;
      cfg_ratio = 32'h0200_0000;
      stream(40, outs, ticks);
      check(ratio_used == 32'h0200_0000, "R9", "programmed ratio selected", ratio_used,
            32'h0200_0000);
      check(ticks == outs / 4, "R6", "strobe resumes in programmed mode", ticks, outs / 4);
      odr_run = 1'b0;

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule